// File: doc/BRIEF.md
# Switched-Capacitor Column Output-Bus Sequencer

This block holds the digital control for a small group of switched-capacitor columns. Each column has a strobe input that marks its base clock. On each strobe the column moves one step through a cycle of four half-phase ticks and decodes the two non-overlapping phases PHI1 and PHI2. From the current tick, the block drives a registered output-bus enable that connects the column amplifier to its shared bus.

By default the bus follows a sample-and-hold timing. The amplifier is connected only in the late half of PHI2, so the bus keeps its last value while the column resets and settles. A per-column clock-phase input widens the connection to both phases. A global disable bit in the control register widens it to the whole of PHI2 for every column at once.

The same control register selects two alternate column clocks from eight digital-block clock lines. A second register picks, for each column, one of eight modulation sources. The chosen source is XORed with that column's sign input to give an effective sign. The analog switches and comparators sit outside the block, and their levels arrive as plain digital inputs.

Top module: `scbus_seq`

## Requirements
- R1: After a synchronous reset, both registers read back 0. Every column is in tick 0: `phi1`=1, `phi2`=0, `bus_en`=0.
- R2: Each `col_tick` pulse moves that column through tick 0 (PHI1 early), tick 1 (PHI1 late), tick 2 (PHI2 early), tick 3 (PHI2 late), then back to tick 0. `phi1` is 1 in ticks 0 and 1, `phi2` is 1 in ticks 2 and 3, and the two are never 1 together.
- R3: With `col_oe`=1, `col_cph`=0 and the disable bit clear, `bus_en` is 1 only in tick 3.
- R4: With `col_oe`=1 and `col_cph`=1, `bus_en` is 1 in all four ticks, whatever the disable bit.
- R5: With the disable bit set, `col_oe`=1 and `col_cph`=0, `bus_en` is 1 in ticks 2 and 3 and 0 in ticks 0 and 1. This holds for every column.
- R6: With `col_oe`=0, `bus_en` is 0 in every tick.
- R7: `bus_en` changes only on a column tick. A change of `col_oe`, `col_cph` or the disable bit between ticks leaves `bus_en` unchanged until the next tick.
- R8: Control register (address 0) layout: bit 6 is the sample-and-hold disable, bits 5:3 select `alt_clk[1]`, and bits 2:0 select `alt_clk[0]`. Other bits read 0. `alt_clk[k]` equals `dblk_clk[select k]`.
- R9: Modulation register (address 1) holds column c's 3-bit select at bits 4c+2:4c. Other bits read 0, and the fields of columns absent for `NUM_COLS` read 0.
- R10: Modulation select codes map as follows: 0 gives a constant 0; 1 to 4 give comparator bus 0 to 3 (an absent column gives 0); 5 gives `glb_bus[0]`; 6 gives `glb_bus[1]`; 7 gives `bcast_bus`. `eff_sign[c]` equals `col_sign[c]` XOR the chosen source.
- R11: A write with `reg_we`=1 updates the register at `reg_addr` on the clock edge. Without `reg_we`, neither register changes. `reg_rdata` shows the register at `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = modulation |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of addressed register |
| col_tick | input | NUM_COLS | Per-column half-phase advance strobe |
| col_oe | input | NUM_COLS | Per-column bus output enable |
| col_cph | input | NUM_COLS | Per-column clock-phase override |
| col_sign | input | NUM_COLS | Per-column programmed sign |
| cmp_bus | input | NUM_COLS | Comparator bus levels |
| glb_bus | input | 2 | Global bus levels |
| bcast_bus | input | 1 | Broadcast bus level |
| dblk_clk | input | 8 | Digital-block clock lines |
| phi1 | output | NUM_COLS | PHI1 per column |
| phi2 | output | NUM_COLS | PHI2 per column |
| bus_en | output | NUM_COLS | Amplifier-to-bus connect per column |
| eff_sign | output | NUM_COLS | Modulated sign per column |
| alt_clk | output | 2 | Alternate column clocks |

## Verification
The bench builds two copies side by side: `NUM_COLS`=4 and `NUM_COLS`=2. Both share the register bus and the tick strobes. The four-column copy covers all comparator-bus modulation codes and per-column differences in the enable pattern. The two-column copy shows that codes 3 and 4 yield 0, and that the upper modulation fields read back as zero. Only the default width `DW`=16 is used, which fits all four column fields.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int SEL_W    = 3;
    localparam int MAX_COLS = 4;
    localparam int FLD_STEP = 4;

    typedef enum logic [1:0] {
        PH1_EARLY = 2'd0,
        PH1_LATE  = 2'd1,
        PH2_EARLY = 2'd2,
        PH2_LATE  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        MOD_OFF   = 3'd0,
        MOD_CMP0  = 3'd1,
        MOD_CMP1  = 3'd2,
        MOD_CMP2  = 3'd3,
        MOD_CMP3  = 3'd4,
        MOD_GLB0  = 3'd5,
        MOD_GLB1  = 3'd6,
        MOD_BCAST = 3'd7
    } mod_src_e;

    typedef struct packed {
        logic             sh_off;
        logic [SEL_W-1:0] alt1_sel;
        logic [SEL_W-1:0] alt0_sel;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    function automatic phase_e next_phase(phase_e p);
        return phase_e'(2'(p) + 2'd1);
    endfunction

    function automatic logic in_phi1(phase_e p);
        return (p == PH1_EARLY) || (p == PH1_LATE);
    endfunction

    function automatic logic in_phi2(phase_e p);
        return (p == PH2_EARLY) || (p == PH2_LATE);
    endfunction

    // Bus connect decision for a given tick: clock-phase override first,
    // then global hold disable, then default late-PHI2 sampling window.
    function automatic logic bus_drive(phase_e p, logic oe, logic cph, logic sh_off);
        if (!oe)    return 1'b0;
        if (cph)    return 1'b1;
        if (sh_off) return in_phi2(p);
        return p == PH2_LATE;
    endfunction

endpackage

// File: rtl/scb_regs.sv
module scb_regs
    import scb_pkg::*;
#(
    parameter int NUM_COLS = 4,
    parameter int DW       = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic                      addr,
    input  logic [DW-1:0]             wdata,
    output ctrl_t                     ctrl,
    output logic [SEL_W*NUM_COLS-1:0] mod_sel,
    output logic [DW-1:0]             rdata
);
    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] mod_q [NUM_COLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int c = 0; c < NUM_COLS; c++) mod_q[c] <= '0;
        end else if (we) begin
            if (!addr) begin
                ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
            end else begin
                for (int c = 0; c < NUM_COLS; c++)
                    mod_q[c] <= wdata[FLD_STEP*c +: SEL_W];
            end
        end
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_flat
        assign mod_sel[SEL_W*c +: SEL_W] = mod_q[c];
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[CTRL_BITS-1:0] = ctrl_q;
        end else begin
            for (int c = 0; c < NUM_COLS; c++)
                rdata[FLD_STEP*c +: SEL_W] = mod_q[c];
        end
    end

    assign ctrl = ctrl_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // R11: registers move only under a write strobe
    p_no_spurious_write_r11: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(ctrl_q) && $stable(mod_sel)));

endmodule

// File: rtl/scb_col.sv
module scb_col
    import scb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic oe,
    input  logic cph,
    input  logic sh_off,
    output logic phi1,
    output logic phi2,
    output logic bus_en
);
    phase_e phase_q;
    logic   en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH1_EARLY;
            en_q    <= 1'b0;
        end else if (tick) begin
            phase_q <= next_phase(phase_q);
            en_q    <= bus_drive(next_phase(phase_q), oe, cph, sh_off);
        end
    end

    assign phi1   = in_phi1(phase_q);
    assign phi2   = in_phi2(phase_q);
    assign bus_en = en_q;

    // R2: one step per tick in fixed order
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (2'(phase_q) == 2'(2'($past(phase_q)) + 2'd1)));

    // R7: enable frozen between ticks
    p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(bus_en) && $stable(phi1)));

    // R3: without clock-phase override the bus floats in PHI1
    p_float_phi1_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cph) |=> (!phi1 || !bus_en));

    // R4: clock-phase override drives in every tick
    p_cph_full_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cph && oe) |=> bus_en);

    // R5: hold disable tracks PHI2 exactly
    p_shoff_phi2_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && oe && sh_off && !cph) |=> (bus_en == phi2));

    // R6: disabled output never drives
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !oe) |=> !bus_en);

endmodule

// File: rtl/scb_modsel.sv
module scb_modsel
    import scb_pkg::*;
#(
    parameter int NUM_COLS = 4
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_COLS-1:0] cmp_bus,
    input  logic [1:0]          glb_bus,
    input  logic                bcast_bus,
    input  logic                sign,
    output logic                eff_sign
);
    logic [MAX_COLS-1:0] cmp_ext;
    logic                pick;

    always_comb begin
        cmp_ext = '0;
        cmp_ext[NUM_COLS-1:0] = cmp_bus;
        case (mod_src_e'(sel))
            MOD_OFF:   pick = 1'b0;
            MOD_CMP0:  pick = cmp_ext[0];
            MOD_CMP1:  pick = cmp_ext[1];
            MOD_CMP2:  pick = cmp_ext[2];
            MOD_CMP3:  pick = cmp_ext[3];
            MOD_GLB0:  pick = glb_bus[0];
            MOD_GLB1:  pick = glb_bus[1];
            MOD_BCAST: pick = bcast_bus;
            default:   pick = 1'b0;
        endcase
        eff_sign = sign ^ pick;
    end

endmodule

// File: rtl/scbus_seq.sv
module scbus_seq
    import scb_pkg::*;
#(
    parameter int NUM_COLS = 4,
    parameter int DW       = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic                reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NUM_COLS-1:0] col_tick,
    input  logic [NUM_COLS-1:0] col_oe,
    input  logic [NUM_COLS-1:0] col_cph,
    input  logic [NUM_COLS-1:0] col_sign,
    input  logic [NUM_COLS-1:0] cmp_bus,
    input  logic [1:0]          glb_bus,
    input  logic                bcast_bus,
    input  logic [7:0]          dblk_clk,
    output logic [NUM_COLS-1:0] phi1,
    output logic [NUM_COLS-1:0] phi2,
    output logic [NUM_COLS-1:0] bus_en,
    output logic [NUM_COLS-1:0] eff_sign,
    output logic [1:0]          alt_clk
);
    ctrl_t                     ctrl;
    logic [SEL_W*NUM_COLS-1:0] mod_sel;

    scb_regs #(.NUM_COLS(NUM_COLS), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl    (ctrl),
        .mod_sel (mod_sel),
        .rdata   (reg_rdata)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        scb_col u_col (
            .clk    (clk),
            .rst    (rst),
            .tick   (col_tick[c]),
            .oe     (col_oe[c]),
            .cph    (col_cph[c]),
            .sh_off (ctrl.sh_off),
            .phi1   (phi1[c]),
            .phi2   (phi2[c]),
            .bus_en (bus_en[c])
        );

        scb_modsel #(.NUM_COLS(NUM_COLS)) u_mod (
            .sel       (mod_sel[SEL_W*c +: SEL_W]),
            .cmp_bus   (cmp_bus),
            .glb_bus   (glb_bus),
            .bcast_bus (bcast_bus),
            .sign      (col_sign[c]),
            .eff_sign  (eff_sign[c])
        );
    end

    assign alt_clk[0] = dblk_clk[ctrl.alt0_sel];
    assign alt_clk[1] = dblk_clk[ctrl.alt1_sel];

endmodule

// File: tb/scbus_seq_test.sv
module scbus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  tick = '0, oe = '0, cph = '0, sign = '0, cmp = '0;
    logic [1:0]  glb = '0;
    logic        bcast = 1'b0;
    logic [7:0]  dblk = '0;
    logic [15:0] rd4, rd2;
    logic [3:0]  phi1_4, phi2_4, en4, es4;
    logic [1:0]  phi1_2, phi2_2, en2, es2, alt4, alt2;

    int checks = 0, fails = 0, ph = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scbus_seq #(.NUM_COLS(4)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd4), .col_tick(tick), .col_oe(oe),
        .col_cph(cph), .col_sign(sign), .cmp_bus(cmp), .glb_bus(glb),
        .bcast_bus(bcast), .dblk_clk(dblk), .phi1(phi1_4), .phi2(phi2_4),
        .bus_en(en4), .eff_sign(es4), .alt_clk(alt4));

    scbus_seq #(.NUM_COLS(2)) uut_two (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd2), .col_tick(tick[1:0]), .col_oe(oe[1:0]),
        .col_cph(cph[1:0]), .col_sign(sign[1:0]), .cmp_bus(cmp[1:0]), .glb_bus(glb),
        .bcast_bus(bcast), .dblk_clk(dblk), .phi1(phi1_2), .phi2(phi2_2),
        .bus_en(en2), .eff_sign(es2), .alt_clk(alt2));

    // {dis, cph, oe, enable per tick 3..0}
    localparam logic [6:0] EN_VEC [8] = '{
        7'b000_0000, 7'b001_1000, 7'b010_0000, 7'b011_1111,
        7'b100_0000, 7'b101_1100, 7'b110_0000, 7'b111_1111 };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 4'hF;
        @(negedge clk);
        tick = 4'h0;
        ph = (ph + 1) % 4;
    endtask

    function automatic logic exp_en(int p, logic dis, logic c, logic o);
        return o && (c || (dis ? (p >= 2) : (p == 3)));
    endfunction

    function automatic logic exp_pick(logic [2:0] code, logic [3:0] cb, int ncols,
                                      logic [1:0] g, logic b);
        if (code == 0) return 1'b0;
        if (code <= 4) return (int'(code) - 1 < ncols) ? cb[code-1] : 1'b0;
        if (code == 5) return g[0];
        if (code == 6) return g[1];
        return b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        reg_addr = 1'b0; #1;
        chk("R1 ctrl", rd4, 0);
        reg_addr = 1'b1; #1;
        chk("R1 mod", rd4, 0);
        chk("R1 phi1", phi1_4, 4'hF);
        chk("R1 phi2", phi2_4, 4'h0);
        chk("R1 bus_en", en4, 4'h0);

        // Table walk over disable / clock-phase / output enable
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            string tag;
            v = EN_VEC[i];
            tag = !v[4] ? "R6" : v[5] ? "R4" : v[6] ? "R5" : "R3";
            wr(1'b0, {9'b0, v[6], 6'b0});
            cph = {4{v[5]}};
            oe  = {4{v[4]}};
            for (int t = 0; t < 4; t++) begin
                do_tick();
                chk(tag, en4, {4{v[ph]}});
                chk(tag, en2, {2{v[ph]}});
                chk("R2 phi1", phi1_4, {4{ph < 2}});
                chk("R2 phi2", phi2_4, {4{ph >= 2}});
            end
        end

        // Mixed per-column settings
        wr(1'b0, 16'h0000);
        oe = 4'b1011; cph = 4'b0010;
        for (int t = 0; t < 4; t++) begin
            logic [3:0] e;
            do_tick();
            for (int c = 0; c < 4; c++) e[c] = exp_en(ph, 1'b0, cph[c], oe[c]);
            chk("R3 mixed", en4, e);
        end
        wr(1'b0, 16'h0040);
        for (int t = 0; t < 4; t++) begin
            logic [3:0] e;
            do_tick();
            for (int c = 0; c < 4; c++) e[c] = exp_en(ph, 1'b1, cph[c], oe[c]);
            chk("R5 mixed", en4, e);
        end

        // R7: changes wait for the next tick
        wr(1'b0, 16'h0000);
        oe = 4'hF; cph = 4'h0;
        while (ph != 3) do_tick();
        chk("R7 pre", en4, 4'hF);
        oe = 4'h0;
        repeat (3) @(negedge clk);
        chk("R7 oe held", en4, 4'hF);
        do_tick();
        chk("R7 oe applied", en4, 4'h0);
        oe = 4'hF;
        do_tick();
        wr(1'b0, 16'h0040);
        do_tick();
        chk("R7 ph2", en4, 4'hF);
        wr(1'b0, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R7 dis held", en4, 4'hF);

        // R8 / R11 control register layout and alternate clocks
        wr(1'b0, 16'hFFFF);
        reg_addr = 1'b0; #1;
        chk("R8 ctrl mask", rd4, 16'h007F);
        for (int s = 0; s < 8; s++) begin
            wr(1'b0, 16'((7 - s) << 3 | s));
            reg_addr = 1'b0; #1;
            chk("R11 ctrl readback", rd4, 16'((7 - s) << 3 | s));
            dblk = 8'(1 << s); #1;
            chk("R8 alt", alt4, 2'b01);
            dblk = ~8'(1 << s); #1;
            chk("R8 alt inv", alt4, 2'b10);
        end

        // R9 modulation register layout
        wr(1'b1, 16'hFFFF);
        reg_addr = 1'b1; #1;
        chk("R9 mod4", rd4, 16'h7777);
        chk("R9 mod2", rd2, 16'h0077);
        reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = 16'h0000;
        repeat (2) @(negedge clk);
        chk("R11 no write", rd4, 16'h7777);

        // R10 modulation source per code
        for (int code = 0; code < 8; code++) begin
            logic [2:0] k;
            k = 3'(code);
            wr(1'b1, {1'b0, k, 1'b0, k, 1'b0, k, 1'b0, k});
            for (int p = 0; p < 2; p++) begin
                logic [3:0] e4;
                logic [1:0] e2;
                cmp   = p ? 4'b0101 : 4'b1010;
                glb   = p ? 2'b10 : 2'b01;
                bcast = p[0];
                sign  = p ? 4'b1001 : 4'b0110;
                #1;
                for (int c = 0; c < 4; c++) e4[c] = sign[c] ^ exp_pick(k, cmp, 4, glb, bcast);
                for (int c = 0; c < 2; c++) e2[c] = sign[c] ^ exp_pick(k, cmp, 2, glb, bcast);
                chk("R10 sign4", es4, e4);
                chk("R10 sign2", es2, e2);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule